// File: doc/BRIEF.md
# Johnson Counter with Decoded Outputs

This block is a synchronous divide-by-eight counter. The count is held in a four-stage twisted-ring (Johnson) shift register: on every rising clock edge the ring shifts by one place, and the inverted last stage is fed back into the first stage. Eight decoded lines are derived from the ring. Each line is a two-input AND of two neighbouring ring bits, so only one line is high in any legal state. A carry output runs at one eighth of the clock rate and is used to clock the next counter in a chain.

An active-high inhibit input freezes the count. An active-high asynchronous reset returns the ring to its reset pattern, which by default is the all-zero pattern (count 0). Self-correcting logic detects any of the eight unused ring patterns and loads count 0 on the next enabled edge, so the counter cannot stay stuck in a wrong loop after power-up. The reset pattern is a parameter, so a test or an integration can start the ring in any pattern it chooses.

Top module: `johnson_div8`

## Requirements
- R1: While inhibit is low, each rising clock edge advances the count from k to (k+1) mod 8.
- R2: The ring word (first stage in bit 0) steps through 0000, 0001, 0011, 0111, 1111, 1110, 1100, 1000 for counts 0 to 7. At the ports, count k is seen as dec_o equal to 1 shifted left by k.
- R3: In every legal ring state exactly one bit of dec_o is high, namely bit k for count k, and it stays high for exactly one clock period.
- R4: While inhibit is high, rising clock edges are ignored: dec_o and carry_o keep their values.
- R5: Asserting rst forces count 0 at once, with no clock edge needed: dec_o = 8'b0000_0001 and carry_o = 1. This uses the default reset pattern of zero.
- R6: A ring that holds one of the eight unused patterns (for example from the RST_PATTERN parameter) goes to count 0 on the next edge at which inhibit is low. It then follows the normal sequence. While inhibit is high, an unused pattern is held unchanged.
- R7: carry_o is high for counts 0 to 3 and low for counts 4 to 7, a 50% duty square wave at one eighth of the clock rate. It rises only on the wrap from count 7 to count 0.
- R8: rst takes priority over inhibit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock; the ring advances on its rising edge |
| rst | input | 1 | Asynchronous active-high reset to the reset pattern |
| inhibit | input | 1 | Active-high hold; edges are ignored while it is high |
| dec_o | output | 8 | One-hot decoded count, bit k high at count k |
| carry_o | output | 1 | Carry: high for counts 0 to 3, for cascading |

## Verification
The hardest situation to reach from the ports is a ring holding an unused pattern. A correct counter never enters one, and the ports offer no way to load it. The bench therefore builds eight more instances beside the main one, each with an unused pattern as its RST_PATTERN. It holds them with inhibit to show that the bad pattern is frozen. It then checks that every one of them shows count 0 after the first enabled edge and follows the normal sequence after that.

// File: rtl/johnson_pkg.sv
package johnson_pkg;

  // Legal twisted-ring words have at most one boundary between adjacent bits.
  function automatic logic jc_legal(input logic [31:0] q, input int n);
    int edges;
    edges = 0;
    for (int i = 0; i < 31; i++) begin
      if (i < n - 1 && q[i] != q[i+1]) edges++;
    end
    return (edges <= 1);
  endfunction

  // One ring step: shift toward the high end, inverted top bit enters at bit 0.
  function automatic logic [31:0] jc_shift(input logic [31:0] q, input int n);
    logic [31:0] r;
    r    = (q << 1) & ((32'd1 << n) - 32'd1);
    r[0] = ~q[n-1];
    return r;
  endfunction

endpackage

// File: rtl/jc_ring.sv
module jc_ring #(
  parameter int                 STAGES      = 4,
  parameter logic [STAGES-1:0]  RST_PATTERN = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inhibit,
  output logic [STAGES-1:0] ring,
  output logic              legal,
  output logic              step_en
);
  import johnson_pkg::*;

  logic [STAGES-1:0] nxt;
  logic [31:0]       ring_w;

  assign ring_w  = {{(32-STAGES){1'b0}}, ring};
  assign legal   = jc_legal(ring_w, STAGES);
  assign step_en = ~inhibit;

  // anti-lock: an unused pattern is replaced by count 0
  always_comb begin
    if (legal) nxt = jc_shift(ring_w, STAGES)   [STAGES-1:0];
    else       nxt = '0;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)          ring <= RST_PATTERN;
    else if (step_en) ring <= nxt;
  end

  // R6: an unused pattern is left on the first enabled edge
  p_recover_r6: assert property (@(posedge clk) disable iff (rst)
    (step_en && !legal) |=> (legal && ring == '0));

  // R4: inhibited edge leaves the ring untouched
  p_hold_ring_r4: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(ring));

  // R2: a legal ring stays legal
  p_stay_legal_r2: assert property (@(posedge clk) disable iff (rst)
    legal |=> legal);
endmodule

// File: rtl/jc_decode.sv
module jc_decode #(
  parameter int STAGES = 4,
  localparam int NOUT = 2 * STAGES
) (
  input  logic [STAGES-1:0] ring,
  input  logic              legal,
  output logic [NOUT-1:0]   dec
);
  // each line is a two-input gate on neighbouring ring bits
  assign dec[0]      = ~ring[0] & ~ring[STAGES-1];
  assign dec[STAGES] =  ring[0] &  ring[STAGES-1];

  genvar k;
  generate
    for (k = 1; k < STAGES; k++) begin : g_slot
      assign dec[k]        =  ring[k-1] & ~ring[k];
      assign dec[STAGES+k] = ~ring[k-1] &  ring[k];
    end
  endgenerate

  // R3: exactly one line high for every legal pattern
  always_comb begin
    if (legal) begin
      p_onehot_r3: assert ($countones(dec) == 1);
    end
  end
endmodule

// File: rtl/jc_carry.sv
module jc_carry #(
  parameter int STAGES = 4
) (
  input  logic [STAGES-1:0] ring,
  output logic              carry
);
  // first half of the sequence has the top stage clear
  assign carry = ~ring[STAGES-1];
endmodule

// File: rtl/johnson_div8.sv
module johnson_div8 #(
  parameter int                STAGES      = 4,
  parameter logic [STAGES-1:0] RST_PATTERN = '0,
  localparam int NOUT = 2 * STAGES
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inhibit,
  output logic [NOUT-1:0] dec_o,
  output logic            carry_o
);
  logic [STAGES-1:0] ring;
  logic              legal;
  logic              step_en;

  jc_ring #(.STAGES(STAGES), .RST_PATTERN(RST_PATTERN)) u_ring (
    .clk(clk), .rst(rst), .inhibit(inhibit),
    .ring(ring), .legal(legal), .step_en(step_en)
  );

  jc_decode #(.STAGES(STAGES)) u_dec (
    .ring(ring), .legal(legal), .dec(dec_o)
  );

  jc_carry #(.STAGES(STAGES)) u_carry (
    .ring(ring), .carry(carry_o)
  );

  // R1: an enabled edge moves the high line one place up, wrapping
  genvar i;
  generate
    for (i = 0; i < NOUT; i++) begin : g_adv
      p_advance_r1: assert property (@(posedge clk) disable iff (rst)
        (step_en && legal && dec_o[i]) |=> dec_o[(i+1)%NOUT]);
    end
  endgenerate

  // R4: inhibited edges leave every output as it was
  p_hold_out_r4: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> ($stable(dec_o) && $stable(carry_o)));

  // R7: carry rises only together with count 0
  p_carry_rise_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(carry_o) |-> dec_o[0]);

  // R7: carry falls only together with the middle count
  p_carry_fall_r7: assert property (@(posedge clk) disable iff (rst)
    (legal && $fell(carry_o)) |-> dec_o[STAGES]);
endmodule

// File: tb/johnson_div8_tb.sv
module johnson_div8_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inhibit = 1'b0;
  logic [7:0] dec_o;
  logic       carry_o;

  int total = 0;
  int bad = 0;
  int cnt = 0;        // reference count of main instance
  int bcnt = -1;      // reference count of bad-start instances, -1 = not yet recovered

  localparam logic [3:0] BADP [8] = '{4'b0010, 4'b0100, 4'b0101, 4'b0110,
                                      4'b1001, 4'b1010, 4'b1011, 4'b1101};

  logic [7:0] bdec [8];
  logic       bcar [8];
  logic [7:0] snap_dec [8];
  logic       snap_car [8];

  always #10 clk = ~clk;

  johnson_div8 u_dut (.clk(clk), .rst(rst), .inhibit(inhibit),
                      .dec_o(dec_o), .carry_o(carry_o));

  genvar g;
  generate
    for (g = 0; g < 8; g++) begin : g_bad
      johnson_div8 #(.RST_PATTERN(BADP[g])) u_b (
        .clk(clk), .rst(rst), .inhibit(inhibit),
        .dec_o(bdec[g]), .carry_o(bcar[g]));
    end
  endgenerate

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h (t=%0t)", req, got, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_dec(input int c);
    return 8'(1 << c);
  endfunction

  function automatic logic exp_car(input int c);
    return (c < 4);
  endfunction

  // one clock: drive at negedge, model on edge, check mid-high
  task automatic cycle(input logic inh);
    @(negedge clk);
    inhibit = inh;
    @(posedge clk);
    if (!inh) begin
      cnt = (cnt + 1) % 8;
      bcnt = (bcnt < 0) ? 0 : (bcnt + 1) % 8;
    end
    #5;
    chk("R1/R3 dec", dec_o, exp_dec(cnt));
    chk("R7 carry", carry_o, exp_car(cnt));
  endtask

  task automatic check_bad(input string req);
    for (int j = 0; j < 8; j++) begin
      chk(req, bdec[j], exp_dec(bcnt));
      chk(req, bcar[j], exp_car(bcnt));
    end
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    // R5: reset state while reset is held
    chk("R5 reset dec", dec_o, 8'h01);
    chk("R5 reset carry", carry_o, 1'b1);
    @(negedge clk);
    inhibit = 1'b1;
    rst = 1'b0;
    for (int j = 0; j < 8; j++) begin
      snap_dec[j] = bdec[j];
      snap_car[j] = bcar[j];
    end
    // R6/R4: unused patterns stay frozen while inhibited
    cycle(1'b1);
    cycle(1'b1);
    for (int j = 0; j < 8; j++) begin
      chk("R6 held bad dec", bdec[j], snap_dec[j]);
      chk("R6 held bad carry", bcar[j], snap_car[j]);
    end
    // R6: first enabled edge recovers to count 0
    cycle(1'b0);
    check_bad("R6 recover");
    // R2/R3/R7: three full sequences, every cycle compared
    for (int n = 0; n < 24; n++) begin
      cycle(1'b0);
      check_bad("R6 follow");
    end
    // R4: hold in the middle of the sequence
    for (int n = 0; n < 5; n++) cycle(1'b0);
    for (int n = 0; n < 4; n++) cycle(1'b1);
    // mixed enable pattern
    for (int n = 0; n < 20; n++) cycle((n % 3) == 1);
    check_bad("R2 mixed");
    // R5: asynchronous reset mid-cycle, no edge needed
    while (cnt == 0) cycle(1'b0);
    @(negedge clk);
    #3;
    rst = 1'b1;
    #2;
    chk("R5 async dec", dec_o, 8'h01);
    chk("R5 async carry", carry_o, 1'b1);
    // R8: reset wins over inhibit, and over clock edges
    inhibit = 1'b1;
    @(posedge clk);
    #5;
    chk("R8 reset over inhibit", dec_o, 8'h01);
    @(negedge clk);
    rst = 1'b0;
    cnt = 0;
    bcnt = -1;
    cycle(1'b0);
    check_bad("R6 recover again");
    for (int n = 0; n < 16; n++) cycle(1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule